// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

The block maps logical addresses onto physical addresses for a paged memory. Each request address is split into a virtual page number (upper bits) and a page offset (lower bits). The page number is compared against all keys of a small, fully associative translation cache in a single cycle. On a hit the physical address is returned on the next cycle. On a miss the block reads the page number's entry from a local page table, answers one cycle later than a hit, and writes valid entries into the cache.

Each page-table entry has a frame number and a present bit. A request for a page whose entry is not present returns a fault, and the block does not cache that entry. The page table is loaded through a separate write port. A flush input empties the cache when the address space changes. Hit and miss counters let the environment measure the hit ratio.

Top module: `page_xlate`

## Requirements
- R1: The physical address is the frame number placed above the unchanged page offset. With default parameters the offset is bits [11:0] of the 20-bit logical address, the page number is bits [19:12], and the frame is bits [19:12] of the 20-bit physical address.
- R2: When an accepted request hits the cache, `resp_valid_o` is high in the cycle right after the accepting edge, and `hit_cnt_o` increments by one.
- R3: When an accepted request misses, `resp_valid_o` is high two cycles after the accepting edge, and `miss_cnt_o` increments by one.
- R4: A miss whose table entry is present writes the page/frame pair into the cache. The next request to that page hits.
- R5: A miss whose table entry is not present returns `resp_fault_o`=1 with `resp_paddr_o`=0. The entry is not cached, so a repeat request misses and faults again.
- R6: With 4 cache entries, refills fill the slots in round-robin order. A fifth distinct present page evicts the oldest refilled page, and that page then misses.
- R7: A one-cycle pulse on `flush_i` invalidates every cache entry and leaves the replacement pointer where it was. The next request to any page misses.
- R8: `req_ready_o` is low in the cycle after a miss is accepted. A request held on the inputs is accepted only once `req_ready_o` returns high.
- R9: After reset `req_ready_o`=1, `resp_valid_o`=0, both counters are zero and the cache is empty.
- R10: A page-table write does not change a cached translation. The cache keeps returning the old frame until a flush.
- R11: Exactly one single-cycle `resp_valid_o` pulse is produced for each accepted request, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request present |
| req_addr_i | input | LADDR_W | Logical address |
| req_ready_o | output | 1 | Block can accept a request |
| flush_i | input | 1 | Invalidate all cache entries |
| resp_valid_o | output | 1 | Response present, one cycle |
| resp_paddr_o | output | FRAME_W+OFF_W | Physical address |
| resp_fault_o | output | 1 | Page not present |
| pt_we_i | input | 1 | Page-table write enable |
| pt_waddr_i | input | LADDR_W-OFF_W | Page-table write index (page number) |
| pt_wpresent_i | input | 1 | Present bit to write |
| pt_wframe_i | input | FRAME_W | Frame number to write |
| hit_cnt_o | output | CNT_W | Accepted requests that hit |
| miss_cnt_o | output | CNT_W | Accepted requests that missed |

## Verification
The bench goes after the cases where a design's latency or replacement is easy to get wrong:
- **Largest offset and highest page.** A design that drops or shifts offset bits returns a wrong address.
- **Repeated access to a non-present page.** A design that caches the fault would answer the second access in one cycle, not two.
- **Round-robin eviction.** A sixth access brings back an evicted page. A design that evicts the wrong slot shows a hit where a miss is expected, or the reverse.
- **Table rewrite, then flush.** A design that reads the table on every access shows the new frame too early. A design with a broken flush keeps returning the old one.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} xl_state_e;
endpackage

// File: rtl/page_xlate_tlb.sv
module page_xlate_tlb #(
  parameter int ENTRIES = 4,
  parameter int KEY_W   = 8,
  parameter int VAL_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [KEY_W-1:0]   key_i,
  output logic               hit_o,
  output logic [VAL_W-1:0]   val_o,
  output logic [ENTRIES-1:0] hit_vec_o,
  input  logic               fill_i,
  input  logic [KEY_W-1:0]   fill_key_i,
  input  logic [VAL_W-1:0]   fill_val_i
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [VAL_W-1:0]   val_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign hit_vec_o[g] = vld_q[g] && (key_q[g] == key_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        key_q[g] <= '0;
        val_q[g] <= '0;
      end else if (flush_i) begin
        vld_q[g] <= 1'b0;
      end else if (fill_i && (rr_q == PTR_W'(g))) begin
        vld_q[g] <= 1'b1;
        key_q[g] <= fill_key_i;
        val_q[g] <= fill_val_i;
      end
    end
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    val_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec_o[i]) val_o = val_o | val_q[i];
  end

  // pointer advances on every refill, flush leaves it alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      rr_q <= '0;
    else if (fill_i && !flush_i)
      rr_q <= (rr_q == PTR_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/page_xlate_ptab.sv
module page_xlate_ptab #(
  parameter int IDX_W   = 8,
  parameter int FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   waddr_i,
  input  logic               wpresent_i,
  input  logic [FRAME_W-1:0] wframe_i,
  input  logic [IDX_W-1:0]   raddr_i,
  output logic               rpresent_o,
  output logic [FRAME_W-1:0] rframe_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]   present_q;
  logic [FRAME_W-1:0] frame_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) present_q <= '0;
    else if (we_i) present_q[waddr_i] <= wpresent_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) frame_q[waddr_i] <= wframe_i;
  end

  // registered read: one table access per miss
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpresent_o <= 1'b0;
      rframe_o   <= '0;
    end else begin
      rpresent_o <= present_q[raddr_i];
      rframe_o   <= frame_q[raddr_i];
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int LADDR_W = 20,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 8,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [LADDR_W-1:0]         req_addr_i,
  output logic                       req_ready_o,
  input  logic                       flush_i,
  output logic                       resp_valid_o,
  output logic [FRAME_W+OFF_W-1:0]   resp_paddr_o,
  output logic                       resp_fault_o,
  input  logic                       pt_we_i,
  input  logic [LADDR_W-OFF_W-1:0]   pt_waddr_i,
  input  logic                       pt_wpresent_i,
  input  logic [FRAME_W-1:0]         pt_wframe_i,
  output logic [CNT_W-1:0]           hit_cnt_o,
  output logic [CNT_W-1:0]           miss_cnt_o
);
  localparam int VPN_W = LADDR_W - OFF_W;

  xl_state_e           state_q;
  logic [VPN_W-1:0]    vpn_in, vpn_q;
  logic [OFF_W-1:0]    off_in, off_q;
  logic                accept, tlb_hit, pt_present, do_fill;
  logic [FRAME_W-1:0]  tlb_frame, pt_frame;
  logic [ENTRIES-1:0]  tlb_hit_vec;

  assign vpn_in      = req_addr_i[LADDR_W-1:OFF_W];
  assign off_in      = req_addr_i[OFF_W-1:0];
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign do_fill     = (state_q == ST_FILL) && pt_present && !flush_i;

  page_xlate_tlb #(.ENTRIES(ENTRIES), .KEY_W(VPN_W), .VAL_W(FRAME_W)) u_tlb (
    .clk_i, .rst_ni, .flush_i,
    .key_i      (vpn_in),
    .hit_o      (tlb_hit),
    .val_o      (tlb_frame),
    .hit_vec_o  (tlb_hit_vec),
    .fill_i     (do_fill),
    .fill_key_i (vpn_q),
    .fill_val_i (pt_frame)
  );

  page_xlate_ptab #(.IDX_W(VPN_W), .FRAME_W(FRAME_W)) u_ptab (
    .clk_i, .rst_ni,
    .we_i       (pt_we_i),
    .waddr_i    (pt_waddr_i),
    .wpresent_i (pt_wpresent_i),
    .wframe_i   (pt_wframe_i),
    .raddr_i    (vpn_in),
    .rpresent_o (pt_present),
    .rframe_o   (pt_frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      vpn_q        <= '0;
      off_q        <= '0;
      resp_valid_o <= 1'b0;
      resp_paddr_o <= '0;
      resp_fault_o <= 1'b0;
      hit_cnt_o    <= '0;
      miss_cnt_o   <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      if (state_q == ST_FILL) begin
        resp_valid_o <= 1'b1;
        resp_fault_o <= !pt_present;
        resp_paddr_o <= pt_present ? {pt_frame, off_q} : '0;
        state_q      <= ST_IDLE;
      end else if (accept) begin
        if (tlb_hit) begin
          resp_valid_o <= 1'b1;
          resp_fault_o <= 1'b0;
          resp_paddr_o <= {tlb_frame, off_in};
          hit_cnt_o    <= hit_cnt_o + 1'b1;
        end else begin
          vpn_q      <= vpn_in;
          off_q      <= off_in;
          state_q    <= ST_FILL;
          miss_cnt_o <= miss_cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int PADDR_W = 20,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               resp_valid_o,
  input logic               resp_fault_o,
  input logic [PADDR_W-1:0] resp_paddr_o,
  input logic [CNT_W-1:0]   hit_cnt_o,
  input logic [CNT_W-1:0]   miss_cnt_o,
  input logic [ENTRIES-1:0] hit_vec_i
);
  p_one_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));

  p_fill_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> resp_valid_o && req_ready_o);

  p_fault_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_fault_o |-> resp_paddr_o == '0);

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=>
      (hit_cnt_o + miss_cnt_o) == $past(hit_cnt_o + miss_cnt_o) + 1'b1);

  p_accept_answers_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> resp_valid_o || !req_ready_o);

  p_resp_has_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_valid_i && req_ready_o) || $past(!req_ready_o));
endmodule

bind page_xlate page_xlate_chk #(
  .PADDR_W(FRAME_W + OFF_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)
) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .resp_valid_o,
  .resp_fault_o, .resp_paddr_o, .hit_cnt_o, .miss_cnt_o,
  .hit_vec_i (tlb_hit_vec)
);

// File: tb/page_xlate_bench.sv
`timescale 1ns/1ps
module page_xlate_bench;
  localparam int LADDR_W = 20, OFF_W = 12, FRAME_W = 8, ENTRIES = 4, CNT_W = 16;
  localparam int VPN_W = LADDR_W - OFF_W, PADDR_W = FRAME_W + OFF_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, flush = 0, pt_we = 0, pt_wpresent = 0;
  logic [LADDR_W-1:0] req_addr = '0;
  logic [VPN_W-1:0]   pt_waddr = '0;
  logic [FRAME_W-1:0] pt_wframe = '0;
  logic req_ready, resp_valid, resp_fault;
  logic [PADDR_W-1:0] resp_paddr;
  logic [CNT_W-1:0]   hit_cnt, miss_cnt;

  always #2.5 clk = ~clk;

  page_xlate #(.LADDR_W(LADDR_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W),
               .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_page_xlate (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .flush_i(flush), .resp_valid_o(resp_valid),
    .resp_paddr_o(resp_paddr), .resp_fault_o(resp_fault), .pt_we_i(pt_we),
    .pt_waddr_i(pt_waddr), .pt_wpresent_i(pt_wpresent), .pt_wframe_i(pt_wframe),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [PADDR_W-1:0] paddr; logic fault; int due; string tag; } exp_t;
  exp_t sb[$];

  // reference model
  logic             m_pt_p [1<<VPN_W];
  logic [FRAME_W-1:0] m_pt_f [1<<VPN_W];
  logic             m_v [ENTRIES];
  logic [VPN_W-1:0] m_k [ENTRIES];
  logic [FRAME_W-1:0] m_f [ENTRIES];
  int m_ptr = 0, m_hits = 0, m_miss = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pt_write(input int vpn, input bit pres, input int frame);
    @(negedge clk);
    pt_we = 1; pt_waddr = VPN_W'(vpn); pt_wpresent = pres; pt_wframe = FRAME_W'(frame);
    @(negedge clk);
    pt_we = 0;
    m_pt_p[vpn] = pres; m_pt_f[vpn] = FRAME_W'(frame);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
  endtask

  // driver: predicts result and latency, pushes to scoreboard
  task automatic do_req(input int vpn, input int off, input string tag, input bit exp_hit);
    exp_t e;
    int idx = -1;
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && m_k[i] == VPN_W'(vpn)) idx = i;
    chk((idx >= 0) == exp_hit, tag, "model hit plan", idx >= 0, exp_hit);
    e.tag = tag;
    if (idx >= 0) begin
      e.paddr = {m_f[idx], OFF_W'(off)}; e.fault = 0; m_hits++;
    end else begin
      m_miss++;
      if (m_pt_p[vpn]) begin
        e.paddr = {m_pt_f[vpn], OFF_W'(off)}; e.fault = 0;
        m_v[m_ptr] = 1; m_k[m_ptr] = VPN_W'(vpn); m_f[m_ptr] = m_pt_f[vpn];
        m_ptr = (m_ptr + 1) % ENTRIES;
      end else begin
        e.paddr = '0; e.fault = 1;
      end
    end
    @(negedge clk);
    req_valid = 1; req_addr = {VPN_W'(vpn), OFF_W'(off)};
    while (!req_ready) @(negedge clk);
    e.due = cyc + 1 + ((idx >= 0) ? 0 : 1);
    sb.push_back(e);
    @(posedge clk);
    #1 req_valid = 0;
    if (idx < 0) begin
      @(negedge clk);
      chk(req_ready == 0, "R8", "ready during refill", req_ready, 0);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R11", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(resp_paddr == e.paddr, e.tag, "paddr (R1)", resp_paddr, e.paddr);
        chk(resp_fault == e.fault, e.tag, "fault", resp_fault, e.fault);
        chk(cyc == e.due, e.tag, "response cycle", cyc, e.due);
      end
    end else if (rst_n && sb.size() > 0 && sb[0].due < cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(0, "R11", "missing response", cyc, e.due);
    end
  end

  initial begin
    #200000;
    chk(0, "R11", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<VPN_W); i++) begin m_pt_p[i] = 0; m_pt_f[i] = '0; end
    for (int i = 0; i < ENTRIES; i++) begin m_v[i] = 0; m_k[i] = '0; m_f[i] = '0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1, "R9", "ready after reset", req_ready, 1);
    chk(resp_valid == 0, "R9", "resp_valid after reset", resp_valid, 0);
    chk(hit_cnt == 0 && miss_cnt == 0, "R9", "counters after reset", hit_cnt + miss_cnt, 0);
    rst_n = 1;
    pt_write(3, 1, 'h21);  pt_write(5, 1, 'h4A);  pt_write(7, 1, 'h13);
    pt_write(8, 1, 'h88);  pt_write(10, 1, 'hA0); pt_write(9, 0, 'h55);
    pt_write(255, 1, 'hFF);
    do_req(3, 'h123, "R3", 0);   // first touch misses, refills
    do_req(3, 'hFFF, "R2", 1);   // R4: now hits, max offset
    do_req(3, 'h000, "R1", 1);
    do_req(9, 'h456, "R5", 0);   // not present: fault
    do_req(9, 'h456, "R5", 0);   // still a miss
    do_req(5, 'h001, "R4", 0);
    do_req(7, 'h002, "R4", 0);
    do_req(8, 'h003, "R4", 0);   // cache now full
    do_req(10, 'h004, "R6", 0);  // evicts page 3
    do_req(5, 'h005, "R6", 1);
    do_req(3, 'h006, "R6", 0);   // evicted page misses, evicts 5
    do_req(5, 'h007, "R6", 0);   // evicts 7
    do_req(8, 'h008, "R6", 1);
    pt_write(8, 1, 'h3C);
    do_req(8, 'h009, "R10", 1);  // still old frame
    do_flush();
    do_req(8, 'h00A, "R7", 0);   // new frame after flush
    do_req(10, 'h00B, "R7", 0);
    do_req(255, 'hFFF, "R1", 0); // top page, top offset
    do_req(255, 'hABC, "R2", 1);
    do_req(0, 'h000, "R5", 0);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R11", "responses outstanding", sb.size(), 0);
    chk(hit_cnt == CNT_W'(m_hits), "R2", "hit counter", hit_cnt, m_hits);
    chk(miss_cnt == CNT_W'(m_miss), "R3", "miss counter", miss_cnt, m_miss);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule